// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave side of an SPI link for a paged serial flash with a 264-byte SRAM staging buffer. It oversamples the SPI pins with the system clock, shifts in an opcode and a 24-bit address field after every chip-select fall, and then serves the transfer directly or passes it on. Buffer fills, buffer reads, direct page reads from the main array and status reads are handled in the block. Page transfers, compares, programs, erases and rewrites are passed to an operation sequencer. It gets the opcode, page and byte fields when chip select rises.

The host may idle SCK low or high. SI is sampled on rising SCK and SO changes on falling SCK in both cases. The main array is reached through a simple synchronous read port with one cycle of latency. The sequencer reports its state through `busy` and `cmp_result`. SCK must stay in each level for at least SYNC_STAGES+3 system clocks.

Top module: `flash_fe`

## Requirements
- R1: After reset, SO is not driven (`so_oe`=0), `mode3` reads 1 and no hand-off pulse occurs. A transfer starts only on a later chip-select fall.
- R2: Opcode 0x84 takes an 8-bit opcode and a 24-bit field, both MSB first. Field bits [8:0] give the start byte, and a start value of 264 or more is reduced by 264. Each complete data byte is stored at the pointer, which then steps on and wraps from 263 to 0. A partial last byte is dropped.
- R3: Opcode 0x54 takes the 24-bit field (start byte in bits [8:0]) and then 8 dummy bits. Buffer bytes then leave on SO MSB first from the start byte, wrapping from 263 to 0.
- R4: Opcode 0x52 takes page = field bits [17:9] and start byte = field bits [8:0], then 32 dummy bits. Array bytes of that page then stream out and wrap to byte 0 of the same page. The buffer is not altered.
- R5: Opcode 0x57 sends the status byte right after the opcode and repeats it for as long as chip select stays low. Each repeat is sampled afresh when its bit 7 is launched.
- R6: The status byte is {~busy, cmp_result, 3'b001, 3'b000}, bit 7 first.
- R7: Within SYNC_STAGES+2 clocks of a chip-select rise, `so_oe` is 0.
- R8: On each chip-select fall, `mode3` takes the SCK level seen at that instant: 1 for idle high, 0 for idle low.
- R9: Opcodes 0x53, 0x60, 0x83, 0x88, 0x81, 0x50, 0x82 and 0x58 raise `op_valid` for one clock after chip select rises, with `op_code`, `op_page` (field [17:9]) and `op_byte` (field [8:0]). The pulse occurs only if all 32 command bits arrived. Opcode 0x82 also fills the buffer like 0x84.
- R10: While `busy` is 1 at the end of the opcode, every opcode other than 0x57 is discarded. The buffer is left unchanged and no hand-off occurs.
- R11: An unrecognised opcode is ignored until the next chip-select fall. There is no hand-off, no buffer change and SO stays undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Drive enable for SO; 0 means high impedance |
| mode3 | output | 1 | SPI idle level captured at the last chip-select fall |
| busy | input | 1 | Sequencer is running a self-timed operation |
| cmp_result | input | 1 | Result of the latest page compare (1 = mismatch) |
| arr_rd_en | output | 1 | Main-array read request |
| arr_rd_page | output | PAGE_AW | Page being read |
| arr_rd_byte | output | BYTE_AW | Byte within the page |
| arr_rd_data | input | 8 | Array data, one clock after the address |
| op_valid | output | 1 | One-clock hand-off pulse to the sequencer |
| op_code | output | 8 | Opcode handed off |
| op_page | output | PAGE_AW | Page field handed off |
| op_byte | output | BYTE_AW | Byte field handed off |

## Verification
The bench builds the block with its default parameters: 264-byte buffer and page, 9-bit page and byte fields, 8 and 32 dummy bits, and two synchroniser stages. These values let a few short transfers reach the non-power-of-two wrap from 263 to 0, start addresses near the end of the buffer, and the point where the last dummy bit meets the first SO bit. The bench drives SCK with an 8-clock half period, which gives margin over the synchroniser delay between an SCK edge and the response on SO. Both SCK idle levels are used, and the busy and compare inputs change between repeats of the status byte.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

   localparam logic [7:0] OP_PAGE_RD   = 8'h52;
   localparam logic [7:0] OP_BUF_RD    = 8'h54;
   localparam logic [7:0] OP_BUF_WR    = 8'h84;
   localparam logic [7:0] OP_STATUS    = 8'h57;
   localparam logic [7:0] OP_XFER      = 8'h53;
   localparam logic [7:0] OP_COMPARE   = 8'h60;
   localparam logic [7:0] OP_PGM_ERS   = 8'h83;
   localparam logic [7:0] OP_PGM_RAW   = 8'h88;
   localparam logic [7:0] OP_PG_ERASE  = 8'h81;
   localparam logic [7:0] OP_BLK_ERASE = 8'h50;
   localparam logic [7:0] OP_PGM_THRU  = 8'h82;
   localparam logic [7:0] OP_REWRITE   = 8'h58;

   typedef enum logic [3:0] {
      ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_WDATA,
      ST_RDATA, ST_STAT, ST_HOLD, ST_IGN
   } fe_state_e;

   // commands that run in the sequencer once chip select rises
   function automatic logic op_deferred(input logic [7:0] c);
      return (c == OP_XFER)     || (c == OP_COMPARE)  || (c == OP_PGM_ERS) ||
             (c == OP_PGM_RAW)  || (c == OP_PG_ERASE) || (c == OP_BLK_ERASE) ||
             (c == OP_PGM_THRU) || (c == OP_REWRITE);
   endfunction

   // commands the front-end serves itself, status excluded
   function automatic logic op_local(input logic [7:0] c);
      return (c == OP_PAGE_RD) || (c == OP_BUF_RD) || (c == OP_BUF_WR);
   endfunction

endpackage

// File: rtl/flash_fe_sync.sv
module flash_fe_sync #(
   parameter int             STAGES  = 2,
   parameter int             W       = 3,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("flash_fe_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/flash_fe_bufram.sv
module flash_fe_bufram #(
   parameter int DEPTH = 264,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   if (DEPTH > (1 << AW)) begin : g_bad_depth
      $error("flash_fe_bufram: DEPTH does not fit AW");
   end

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/flash_fe_oshift.sv
module flash_fe_oshift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       load,
   input  logic       shift,
   input  logic [7:0] din,
   output logic       so
);

   logic [6:0] rest;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         so   <= 1'b0;
         rest <= '0;
      end else if (clear) begin
         so   <= 1'b0;
         rest <= '0;
      end else if (load) begin
         {so, rest} <= din;
      end else if (shift) begin
         {so, rest} <= {rest, 1'b0};
      end
   end

endmodule

// File: rtl/flash_fe.sv
module flash_fe import flash_fe_pkg::*; #(
   parameter int         BUF_BYTES   = 264,
   parameter int         PAGE_BYTES  = 264,
   parameter int         PAGE_AW     = 9,
   parameter int         BYTE_AW     = 9,
   parameter int         ADDR_BITS   = 24,
   parameter int         BUFRD_DUMMY = 8,
   parameter int         PGRD_DUMMY  = 32,
   parameter int         SYNC_STAGES = 2,
   parameter logic [2:0] DENSITY     = 3'b001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck,
   input  logic               cs_n,
   input  logic               si,
   output logic               so,
   output logic               so_oe,
   output logic               mode3,
   input  logic               busy,
   input  logic               cmp_result,
   output logic               arr_rd_en,
   output logic [PAGE_AW-1:0] arr_rd_page,
   output logic [BYTE_AW-1:0] arr_rd_byte,
   input  logic [7:0]         arr_rd_data,
   output logic               op_valid,
   output logic [7:0]         op_code,
   output logic [PAGE_AW-1:0] op_page,
   output logic [BYTE_AW-1:0] op_byte
);

   localparam int CW = $clog2(ADDR_BITS + PGRD_DUMMY + BUFRD_DUMMY + 1);
   localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_BITS - 1);
   localparam logic [CW-1:0] BRD_LAST  = CW'(BUFRD_DUMMY - 1);
   localparam logic [CW-1:0] PRD_LAST  = CW'(PGRD_DUMMY - 1);
   localparam logic [CW-1:0] OPC_LAST  = CW'(7);
   localparam logic [BYTE_AW-1:0] BUF_LIM = BYTE_AW'(BUF_BYTES);
   localparam logic [BYTE_AW-1:0] PG_LIM  = BYTE_AW'(PAGE_BYTES);

   // elaboration-time parameter checks
   if (PAGE_AW + BYTE_AW > ADDR_BITS) begin : g_bad_fields
      $error("flash_fe: page and byte fields exceed the address field");
   end
   if (BUF_BYTES >= (1 << BYTE_AW) || PAGE_BYTES >= (1 << BYTE_AW)) begin : g_bad_lim
      $error("flash_fe: byte field too narrow for buffer or page size");
   end
   if ((1 << BYTE_AW) > 2 * BUF_BYTES || (1 << BYTE_AW) > 2 * PAGE_BYTES) begin : g_bad_fold
      $error("flash_fe: start-address fold needs field range below twice the size");
   end
   if (BUFRD_DUMMY < 1 || PGRD_DUMMY < 1) begin : g_bad_dummy
      $error("flash_fe: dummy counts must be positive");
   end

   function automatic logic [BYTE_AW-1:0] ptr_step(input logic [BYTE_AW-1:0] p,
                                                   input logic [BYTE_AW-1:0] lim);
      return (p == lim - 1'b1) ? '0 : p + 1'b1;
   endfunction

   function automatic logic [BYTE_AW-1:0] ptr_fold(input logic [BYTE_AW-1:0] p,
                                                   input logic [BYTE_AW-1:0] lim);
      return (p >= lim) ? p - lim : p;
   endfunction

   // ---------------- pin synchronisation and edge detection
   logic [2:0] sync_q;
   logic       sck_s, cs_s, si_s;
   logic       sck_p, cs_p;

   flash_fe_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck, cs_n, si}),
      .q     (sync_q)
   );
   assign {sck_s, cs_s, si_s} = sync_q;

   logic sck_rise, sck_fall, cs_fall, cs_rise;
   assign sck_rise = sck_s & ~sck_p & ~cs_s;
   assign sck_fall = ~sck_s & sck_p & ~cs_s;
   assign cs_fall  = ~cs_s & cs_p;
   assign cs_rise  = cs_s & ~cs_p;

   // ---------------- command state
   fe_state_e          st;
   logic [CW-1:0]      cnt;
   logic [7:0]         opc_sh, opc;
   logic [ADDR_BITS-1:0] addr_sh;
   logic [BYTE_AW-1:0] ptr;
   logic [PAGE_AW-1:0] pg;
   logic [6:0]         wsh;
   logic [2:0]         obit;
   logic               oe;
   logic               buf_we;
   logic [BYTE_AW-1:0] buf_waddr;
   logic [7:0]         buf_wdata;
   logic [7:0]         buf_rdata;

   logic [7:0]           opc_next;
   logic [ADDR_BITS-1:0] addr_next;
   logic [7:0]           wbyte;
   logic [BYTE_AW-1:0]   start_fld;
   logic [BYTE_AW-1:0]   cur_lim;

   always_comb begin
      opc_next  = {opc_sh[6:0], si_s};
      addr_next = {addr_sh[ADDR_BITS-2:0], si_s};
      wbyte     = {wsh, si_s};
      start_fld = addr_next[BYTE_AW-1:0];
      cur_lim   = (opc == OP_PAGE_RD) ? PG_LIM : BUF_LIM;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p     <= 1'b1;
         cs_p      <= 1'b1;
         st        <= ST_IDLE;
         cnt       <= '0;
         opc_sh    <= '0;
         opc       <= '0;
         addr_sh   <= '0;
         ptr       <= '0;
         pg        <= '0;
         wsh       <= '0;
         obit      <= '0;
         oe        <= 1'b0;
         mode3     <= 1'b1;
         buf_we    <= 1'b0;
         buf_waddr <= '0;
         buf_wdata <= '0;
         op_valid  <= 1'b0;
         op_code   <= '0;
         op_page   <= '0;
         op_byte   <= '0;
      end else begin
         sck_p    <= sck_s;
         cs_p     <= cs_s;
         op_valid <= 1'b0;
         buf_we   <= 1'b0;
         if (cs_fall) begin
            st    <= ST_OPC;
            cnt   <= '0;
            obit  <= '0;
            oe    <= 1'b0;
            mode3 <= sck_s;
         end else if (cs_rise) begin
            if (st == ST_HOLD || (st == ST_WDATA && opc == OP_PGM_THRU))
               op_valid <= 1'b1;
            st <= ST_IDLE;
            oe <= 1'b0;
         end else if (sck_rise) begin
            unique case (st)
               ST_OPC: begin
                  opc_sh <= opc_next;
                  cnt    <= cnt + 1'b1;
                  if (cnt == OPC_LAST) begin
                     opc  <= opc_next;
                     cnt  <= '0;
                     obit <= '0;
                     if (opc_next == OP_STATUS)
                        st <= ST_STAT;
                     else if (busy || !(op_local(opc_next) || op_deferred(opc_next)))
                        st <= ST_IGN;
                     else
                        st <= ST_ADDR;
                  end
               end
               ST_ADDR: begin
                  addr_sh <= addr_next;
                  cnt     <= cnt + 1'b1;
                  if (cnt == ADDR_LAST) begin
                     cnt     <= '0;
                     obit    <= '0;
                     pg      <= addr_next[BYTE_AW +: PAGE_AW];
                     ptr     <= ptr_fold(start_fld, cur_lim);
                     op_code <= opc;
                     op_page <= addr_next[BYTE_AW +: PAGE_AW];
                     op_byte <= start_fld;
                     if (opc == OP_BUF_WR || opc == OP_PGM_THRU) st <= ST_WDATA;
                     else if (opc == OP_BUF_RD || opc == OP_PAGE_RD) st <= ST_DUMMY;
                     else st <= ST_HOLD;
                  end
               end
               ST_DUMMY: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == ((opc == OP_BUF_RD) ? BRD_LAST : PRD_LAST)) begin
                     cnt  <= '0;
                     obit <= '0;
                     st   <= ST_RDATA;
                  end
               end
               ST_WDATA: begin
                  wsh  <= wbyte[6:0];
                  obit <= obit + 1'b1;
                  if (obit == 3'd7) begin
                     buf_we    <= 1'b1;
                     buf_waddr <= ptr;
                     buf_wdata <= wbyte;
                     ptr       <= ptr_step(ptr, BUF_LIM);
                  end
               end
               default: ;
            endcase
         end else if (sck_fall && (st == ST_RDATA || st == ST_STAT)) begin
            oe   <= 1'b1;
            obit <= obit + 1'b1;
            if (st == ST_RDATA && obit == 3'd0)
               ptr <= ptr_step(ptr, cur_lim);
         end
      end
   end

   // ---------------- data sources and output shifter
   logic       out_go, sh_load, sh_shift;
   logic [7:0] status_byte, src_byte;

   always_comb begin
      out_go      = sck_fall && !cs_fall && (st == ST_RDATA || st == ST_STAT);
      sh_load     = out_go && (obit == 3'd0);
      sh_shift    = out_go && (obit != 3'd0);
      status_byte = {~busy, cmp_result, DENSITY, 3'b000};
      if (st == ST_STAT)          src_byte = status_byte;
      else if (opc == OP_BUF_RD)  src_byte = buf_rdata;
      else                        src_byte = arr_rd_data;
   end

   flash_fe_bufram #(.DEPTH(BUF_BYTES), .AW(BYTE_AW)) u_buf (
      .clk   (clk),
      .we    (buf_we),
      .waddr (buf_waddr),
      .wdata (buf_wdata),
      .raddr (ptr),
      .rdata (buf_rdata)
   );

   flash_fe_oshift u_osh (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (cs_fall),
      .load  (sh_load),
      .shift (sh_shift),
      .din   (src_byte),
      .so    (so)
   );

   assign so_oe       = oe;
   assign arr_rd_en   = (st == ST_DUMMY || st == ST_RDATA) && (opc == OP_PAGE_RD);
   assign arr_rd_page = pg;
   assign arr_rd_byte = ptr;

endmodule

// File: rtl/flash_fe_chk.sv
module flash_fe_chk #(
   parameter int BUF_BYTES = 264,
   parameter int PAGE_AW   = 9,
   parameter int BYTE_AW   = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cs_s,
   input logic               sck_s,
   input logic               so_oe,
   input logic               mode3,
   input logic               op_valid,
   input logic               buf_we,
   input logic [BYTE_AW-1:0] buf_waddr,
   input logic               arr_rd_en,
   input logic [PAGE_AW-1:0] arr_rd_page
);

   localparam logic [BYTE_AW-1:0] LIM = BYTE_AW'(BUF_BYTES);

   p_write_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (buf_waddr < LIM));

   p_page_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_rd_en && $past(arr_rd_en)) |-> $stable(arr_rd_page));

   p_release_so_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_s) |=> !so_oe);

   p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_s) |=> (mode3 == $past(sck_s)));

   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> !op_valid);

   p_handoff_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> cs_s);

endmodule

bind flash_fe flash_fe_chk #(
   .BUF_BYTES (BUF_BYTES),
   .PAGE_AW   (PAGE_AW),
   .BYTE_AW   (BYTE_AW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_s        (cs_s),
   .sck_s       (sck_s),
   .so_oe       (so_oe),
   .mode3       (mode3),
   .op_valid    (op_valid),
   .buf_we      (buf_we),
   .buf_waddr   (buf_waddr),
   .arr_rd_en   (arr_rd_en),
   .arr_rd_page (arr_rd_page)
);

// File: tb/flash_fe_bench.sv
module flash_fe_bench;

   localparam int H   = 8;
   localparam int BSZ = 264;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b1, cs_n = 1'b1, si = 1'b0;
   logic       so, so_oe, mode3;
   logic       busy = 1'b0, cmp_result = 1'b0;
   logic       arr_rd_en;
   logic [8:0] arr_rd_page, arr_rd_byte;
   logic [7:0] arr_rd_data = 8'h00;
   logic       op_valid;
   logic [7:0] op_code;
   logic [8:0] op_page, op_byte;

   always #4 clk = ~clk;

   flash_fe u_flash_fe (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
      .so(so), .so_oe(so_oe), .mode3(mode3), .busy(busy), .cmp_result(cmp_result),
      .arr_rd_en(arr_rd_en), .arr_rd_page(arr_rd_page), .arr_rd_byte(arr_rd_byte),
      .arr_rd_data(arr_rd_data), .op_valid(op_valid), .op_code(op_code),
      .op_page(op_page), .op_byte(op_byte)
   );

   int n_chk = 0, n_err = 0, n_ops = 0;
   bit done = 0;
   bit cur_m3 = 1;
   logic [7:0] bm [BSZ];
   logic [7:0] last_code;
   logic [8:0] last_page, last_byte;
   bit oe_seen_low;

   function automatic logic [7:0] arr_pat(input int p, input int b);
      return 8'(((p * 29) + (b * 7)) ^ 165);
   endfunction

   function automatic logic [7:0] exp_status(input logic bz, input logic cm);
      return {~bz, cm, 3'b001, 3'b000};
   endfunction

   // array model: one clock of latency
   always @(posedge clk)
      arr_rd_data <= arr_rd_en ? arr_pat(int'(arr_rd_page), int'(arr_rd_byte)) : 8'h00;

   // hand-off monitor
   always @(posedge clk)
      if (rst_n && op_valid) begin
         n_ops++;
         last_code = op_code;
         last_page = op_page;
         last_byte = op_byte;
      end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic b, output logic r);
      sck <= 1'b0;
      si  <= b;
      wclk(H);
      r = so;
      if (!so_oe) oe_seen_low = 1;
      sck <= 1'b1;
      wclk(H);
   endtask

   task automatic begin_txn(input bit m3);
      cur_m3 = m3;
      sck <= m3;
      wclk(6);
      cs_n <= 1'b0;
      wclk(H);
      oe_seen_low = 0;
   endtask

   task automatic end_txn();
      if (!cur_m3) begin
         wclk(H);
         sck <= 1'b0;
      end
      wclk(H);
      cs_n <= 1'b1;
      wclk(12);
   endtask

   task automatic send_byte(input logic [7:0] b);
      logic r;
      for (int i = 7; i >= 0; i--) sbit(b[i], r);
   endtask

   task automatic recv_byte(output logic [7:0] v);
      logic r;
      oe_seen_low = 0;
      for (int i = 7; i >= 0; i--) begin
         sbit(1'b0, r);
         v[i] = r;
      end
   endtask

   task automatic send_hdr(input logic [7:0] op, input int page, input int start);
      logic [23:0] a;
      a = {6'b0, 9'(page), 9'(start)};
      send_byte(op);
      send_byte(a[23:16]);
      send_byte(a[15:8]);
      send_byte(a[7:0]);
   endtask

   task automatic buf_write(input logic [7:0] op, input bit m3, input int page,
                            input int start, input int len, input bit upd);
      logic [7:0] b;
      begin_txn(m3);
      send_hdr(op, page, start);
      for (int k = 0; k < len; k++) begin
         b = 8'($urandom);
         send_byte(b);
         if (upd) bm[(start + k) % BSZ] = b;
      end
      end_txn();
   endtask

   task automatic buf_read_chk(input bit m3, input int start, input int len, input string req);
      logic [7:0] v;
      logic r;
      begin_txn(m3);
      send_hdr(8'h54, 0, start);
      for (int k = 0; k < 8; k++) sbit(1'b0, r);
      for (int k = 0; k < len; k++) begin
         recv_byte(v);
         chk(req, v, bm[(start + k) % BSZ]);
         chk(req, oe_seen_low, 0);
      end
      end_txn();
   endtask

   task automatic final_report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         final_report();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic r;
      int ops0;
      void'($urandom(32'd1234));

      // R1: reset state
      wclk(5);
      chk("R1 so_oe", so_oe, 0);
      chk("R1 mode3", mode3, 1);
      rst_n <= 1'b1;
      wclk(10);
      chk("R1 so_oe after release", so_oe, 0);
      chk("R1 mode3 after release", mode3, 1);
      chk("R1 no handoff", n_ops, 0);

      // R2: fill the whole buffer, idle-low clock
      buf_write(8'h84, 0, 0, 0, BSZ, 1);
      chk("R8 idle low", mode3, 0);

      // R3: read across the 263->0 wrap, idle-high clock
      buf_read_chk(1, 258, 12, "R3 buffer read wrap");
      chk("R8 idle high", mode3, 1);
      chk("R7 so released", so_oe, 0);

      // R2: write across the wrap, then a partial byte that must be dropped
      begin_txn(1);
      send_hdr(8'h84, 0, 261);
      for (int k = 0; k < 6; k++) begin
         v = 8'($urandom);
         send_byte(v);
         bm[(261 + k) % BSZ] = v;
      end
      sbit(1'b1, r); sbit(1'b0, r); sbit(1'b1, r);
      end_txn();
      buf_read_chk(0, 259, 10, "R2 write wrap and partial byte");

      // R2: start field 300 folds to 36
      buf_write(8'h84, 1, 0, 300, 2, 0);
      bm[36] = 8'hxx;
      begin_txn(0);
      send_hdr(8'h54, 0, 36);
      for (int k = 0; k < 8; k++) sbit(1'b0, r);
      end_txn();
      // re-write the folded location with a known value and read it back
      begin_txn(1);
      send_hdr(8'h84, 0, 300);
      send_byte(8'h3C);
      send_byte(8'hC3);
      end_txn();
      bm[36] = 8'h3C;
      bm[37] = 8'hC3;
      buf_read_chk(1, 36, 2, "R2 start fold");

      // R2 R3: random write/read rounds
      for (int it = 0; it < 5; it++) begin
         int st, ln;
         bit m;
         st = int'($urandom % BSZ);
         ln = 1 + int'($urandom % 5);
         m  = 1'($urandom);
         buf_write(8'h84, m, 0, st, ln, 1);
         buf_read_chk(~m, st, ln, "R3 random round");
      end

      // R4: page read with wrap inside the page
      begin_txn(0);
      send_hdr(8'h52, 9'h0AB, 261);
      for (int k = 0; k < 32; k++) sbit(1'b0, r);
      for (int k = 0; k < 6; k++) begin
         recv_byte(v);
         chk("R4 page read", v, arr_pat(9'h0AB, (261 + k) % BSZ));
      end
      end_txn();
      buf_read_chk(1, 0, 4, "R4 buffer untouched");

      // R5 R6: repeating status with fresh values
      busy = 0; cmp_result = 0;
      begin_txn(1);
      send_byte(8'h57);
      recv_byte(v);
      chk("R6 status ready", v, exp_status(0, 0));
      busy = 1; cmp_result = 1;
      recv_byte(v);
      chk("R5 status repeat busy", v, exp_status(1, 1));
      busy = 0;
      recv_byte(v);
      chk("R5 status repeat ready", v, exp_status(0, 1));
      end_txn();
      chk("R7 so released after status", so_oe, 0);
      cmp_result = 0;

      // R9: deferred commands
      ops0 = n_ops;
      begin_txn(0);
      send_hdr(8'h83, 9'h1A5, 0);
      end_txn();
      chk("R9 pulse count", n_ops, ops0 + 1);
      chk("R9 opcode", last_code, 8'h83);
      chk("R9 page", last_page, 9'h1A5);

      begin_txn(1);
      send_hdr(8'h50, 9'h0F8, 0);
      end_txn();
      chk("R9 block erase opcode", last_code, 8'h50);
      chk("R9 block erase page", last_page, 9'h0F8);

      ops0 = n_ops;
      buf_write(8'h82, 1, 9'h033, 5, 2, 1);
      chk("R9 program-through pulse", n_ops, ops0 + 1);
      chk("R9 program-through byte", last_byte, 9'd5);
      buf_read_chk(0, 5, 2, "R9 program-through buffer");

      // R9: incomplete address gives no hand-off
      ops0 = n_ops;
      begin_txn(0);
      send_byte(8'h88);
      send_byte(8'h00);
      send_byte(8'h12);
      end_txn();
      chk("R9 incomplete command", n_ops, ops0);

      // R10: busy discards everything but status
      busy = 1;
      ops0 = n_ops;
      buf_write(8'h84, 0, 0, 10, 2, 0);
      begin_txn(1);
      send_hdr(8'h83, 9'h044, 0);
      end_txn();
      chk("R10 no handoff while busy", n_ops, ops0);
      begin_txn(0);
      send_byte(8'h57);
      recv_byte(v);
      end_txn();
      chk("R10 status while busy", v, exp_status(1, 0));
      busy = 0;
      buf_read_chk(1, 10, 2, "R10 buffer unchanged");

      // R11: unknown opcode
      ops0 = n_ops;
      begin_txn(1);
      send_hdr(8'hA7, 9'h011, 0);
      for (int k = 0; k < 16; k++) sbit(1'b1, r);
      chk("R11 so stays undriven", oe_seen_low && !so_oe, 1);
      end_txn();
      chk("R11 no handoff", n_ops, ops0);
      buf_read_chk(0, 0, 2, "R11 buffer unchanged");

      done = 1;
      final_report();
      $finish;
   end

endmodule